// File: doc/BRIEF.md
# Fine-Grained Multithread Fetch Scheduler

This block decides which hardware thread fetches in each cycle of an in-order pipeline that interleaves threads cycle by cycle. It keeps one program counter per thread, picks the fetching thread in rotating order, and records which thread holds each pipeline slot from fetch through write-back. The stage count comes from parameters. The default is a five-slot pipeline. A longer variant with eight execute slots and two memory slots uses the same logic.

When the fetched word is a branch, the front end raises `fetch_is_br_i`. The owning thread then stays out of fetch until the execute logic reports the outcome on the `br_*` inputs. The thread's PC then takes either the target or the next sequential address. When enough threads are in rotation, no thread ever has two dependent instructions in flight at once. This removes the need for interlock and branch-stall logic elsewhere. Register files, caches and the ALU sit outside this block.

Top module: `mtf_sched`

## Requirements
- R1: After reset, thread t holds PC `BOOT_PC + t*BOOT_STRIDE` and no thread has a branch pending. The first fetch goes to thread 0, and every slot behind fetch is empty.
- R2: Selection is round-robin. The search starts at the thread after the last one that fetched and wraps from `N_THR-1` to 0. It takes the first thread that has no branch pending.
- R3: A fetch with `fetch_is_br_i` low moves that thread's PC forward by 4 for its next fetch.
- R4: A fetch with `fetch_is_br_i` high leaves that thread's PC unchanged and marks a branch as pending. A thread with a branch pending is never selected.
- R5: When `br_valid_i` is high, thread `br_tid_i` has its pending mark cleared on the same clock edge. Its PC becomes `br_target_i` if `br_taken_i` is 1, or its held PC plus 4 if `br_taken_i` is 0. The thread may fetch in the next cycle.
- R6: When every thread has a branch pending, `fetch_valid_o` is low. No PC changes and the rotation point stays where it was.
- R7: Slot 0 of `stg_vld_o`/`stg_tid_o` shows the current fetch. Slot k shows the fetch from k cycles earlier, including bubbles. The slot count is `3+N_EX+N_MEM`, and thread IDs are packed `TID_W` bits per slot with slot 0 in the low bits.
- R8: `fetch_is_br_i` has no effect during a bubble cycle.
- R9: A resolution may only be reported for a thread that has a branch pending, in the cycle when that branch occupies slot 2 (the first execute slot).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_is_br_i | input | 1 | The word fetched this cycle is a branch |
| br_valid_i | input | 1 | A branch resolves this cycle |
| br_tid_i | input | TID_W | Thread of the resolving branch |
| br_taken_i | input | 1 | Resolved direction, 1 = taken |
| br_target_i | input | PC_W | Taken target address |
| fetch_valid_o | output | 1 | A thread fetches this cycle (0 = bubble) |
| fetch_tid_o | output | TID_W | Fetching thread |
| fetch_pc_o | output | PC_W | Fetch address |
| stg_vld_o | output | N_STG | Slot occupied, bit k = slot k |
| stg_tid_o | output | N_STG*TID_W | Thread in each slot |

## Verification
The assertions assume that the execute logic reports a resolution only for a thread that is waiting on a branch. They also assume the report arrives in the exact cycle that thread's branch sits in slot 2. The bench meets both conditions by deriving `br_valid_i` from its own model of slot 2 and never from a free-running pattern. The bench runs the long variant with two threads. This makes cycles with every thread blocked reachable. It drives `fetch_is_br_i` high during those bubbles to show that the input is ignored.

// File: rtl/mtf_pkg.sv
package mtf_pkg;
  localparam int unsigned PC_STEP = 4;
  localparam int unsigned RES_STG = 2;  // first execute slot
endpackage

// File: rtl/mtf_rr_pick.sv
module mtf_rr_pick #(
  parameter int unsigned N_THR = 4,
  parameter int unsigned TID_W = 2
) (
  input  logic [N_THR-1:0] block_i,
  input  logic [TID_W-1:0] head_i,
  output logic             hit_o,
  output logic [TID_W-1:0] tid_o
);
  // walk from the far end so the nearest free thread wins
  always_comb begin
    hit_o = 1'b0;
    tid_o = '0;
    for (int i = N_THR - 1; i >= 0; i--) begin
      logic [TID_W:0] idx;
      idx = {1'b0, head_i} + (TID_W+1)'(i);
      if (idx >= (TID_W+1)'(N_THR)) idx = idx - (TID_W+1)'(N_THR);
      if (!block_i[idx[TID_W-1:0]]) begin
        hit_o = 1'b1;
        tid_o = idx[TID_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mtf_thr_ctx.sv
module mtf_thr_ctx #(
  parameter int unsigned PC_W   = 32,
  parameter logic [PC_W-1:0] RST_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic            is_br_i,
  input  logic            res_i,
  input  logic            taken_i,
  input  logic [PC_W-1:0] tgt_i,
  output logic [PC_W-1:0] pc_o,
  output logic            pend_o
);
  import mtf_pkg::*;

  logic [PC_W-1:0] pc_q;
  logic            pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= RST_PC;
      pend_q <= 1'b0;
    end else if (res_i) begin
      pc_q   <= taken_i ? tgt_i : pc_q + PC_W'(PC_STEP);
      pend_q <= 1'b0;
    end else if (fire_i) begin
      if (is_br_i) pend_q <= 1'b1;
      else         pc_q   <= pc_q + PC_W'(PC_STEP);
    end
  end

  assign pc_o   = pc_q;
  assign pend_o = pend_q;

  AST_RES_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_i |-> pend_q); // R9
  AST_PEND_NO_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> !pend_q); // R4
  AST_RES_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_i |=> !pend_q); // R5
endmodule

// File: rtl/mtf_stage_trk.sv
module mtf_stage_trk #(
  parameter int unsigned N_STG = 5,
  parameter int unsigned TID_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_vld_i,
  input  logic [TID_W-1:0]       in_tid_i,
  output logic [N_STG-1:0]       vld_o,
  output logic [N_STG*TID_W-1:0] tid_o
);
  logic             vld_w [N_STG];
  logic [TID_W-1:0] tid_w [N_STG];

  assign vld_w[0] = in_vld_i;
  assign tid_w[0] = in_tid_i;

  for (genvar s = 1; s < N_STG; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_w[s] <= 1'b0;
        tid_w[s] <= '0;
      end else begin
        vld_w[s] <= vld_w[s-1];
        tid_w[s] <= tid_w[s-1];
      end
    end
  end

  for (genvar s = 0; s < N_STG; s++) begin : g_out
    assign vld_o[s]                  = vld_w[s];
    assign tid_o[s*TID_W +: TID_W]   = tid_w[s];
  end
endmodule

// File: rtl/mtf_sched.sv
module mtf_sched #(
  parameter int unsigned N_THR  = 4,
  parameter int unsigned PC_W   = 32,
  parameter int unsigned N_EX   = 1,
  parameter int unsigned N_MEM  = 1,
  parameter logic [PC_W-1:0] BOOT_PC     = '0,
  parameter logic [PC_W-1:0] BOOT_STRIDE = PC_W'(32'h1000),
  localparam int unsigned TID_W = (N_THR > 1) ? $clog2(N_THR) : 1,
  localparam int unsigned N_STG = 3 + N_EX + N_MEM
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fetch_is_br_i,
  input  logic                   br_valid_i,
  input  logic [TID_W-1:0]       br_tid_i,
  input  logic                   br_taken_i,
  input  logic [PC_W-1:0]        br_target_i,
  output logic                   fetch_valid_o,
  output logic [TID_W-1:0]       fetch_tid_o,
  output logic [PC_W-1:0]        fetch_pc_o,
  output logic [N_STG-1:0]       stg_vld_o,
  output logic [N_STG*TID_W-1:0] stg_tid_o
);
  import mtf_pkg::*;

  logic [N_THR-1:0] pend_w;
  logic [PC_W-1:0]  pc_w [N_THR];
  logic [TID_W-1:0] rr_q;
  logic             hit_w;
  logic [TID_W-1:0] sel_w;

  mtf_rr_pick #(.N_THR(N_THR), .TID_W(TID_W)) u_pick (
    .block_i (pend_w),
    .head_i  (rr_q),
    .hit_o   (hit_w),
    .tid_o   (sel_w)
  );

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    mtf_thr_ctx #(
      .PC_W   (PC_W),
      .RST_PC (BOOT_PC + PC_W'(t) * BOOT_STRIDE)
    ) u_ctx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fire_i  (hit_w && (sel_w == TID_W'(t))),
      .is_br_i (fetch_is_br_i),
      .res_i   (br_valid_i && (br_tid_i == TID_W'(t))),
      .taken_i (br_taken_i),
      .tgt_i   (br_target_i),
      .pc_o    (pc_w[t]),
      .pend_o  (pend_w[t])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rr_q <= '0;
    else if (hit_w) rr_q <= (sel_w == TID_W'(N_THR - 1)) ? '0 : sel_w + 1'b1;
  end

  assign fetch_valid_o = hit_w;
  assign fetch_tid_o   = sel_w;
  assign fetch_pc_o    = pc_w[sel_w];

  mtf_stage_trk #(.N_STG(N_STG), .TID_W(TID_W)) u_trk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_vld_i (hit_w),
    .in_tid_i (sel_w),
    .vld_o    (stg_vld_o),
    .tid_o    (stg_tid_o)
  );

  AST_BUBBLE_ALL_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_o |-> (&pend_w)); // R6
  AST_RES_IN_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_valid_i |-> (stg_vld_o[RES_STG] &&
                    stg_tid_o[RES_STG*TID_W +: TID_W] == br_tid_i)); // R9
  AST_BR_HOLDS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_o && fetch_is_br_i) |=>
      !(fetch_valid_o && fetch_tid_o == $past(fetch_tid_o))); // R4
endmodule

// File: tb/sim_mtf_sched.sv
module sim_mtf_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NT   = 2;
  localparam int NEX  = 8;
  localparam int NMEM = 2;
  localparam int NS   = 3 + NEX + NMEM;
  localparam int TW   = 1;
  localparam int PW   = 32;
  localparam logic [PW-1:0] BOOT   = 32'h0000_1000;
  localparam logic [PW-1:0] STRIDE = 32'h0000_0100;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fetch_is_br_i = 1'b0;
  logic br_valid_i = 1'b0;
  logic [TW-1:0] br_tid_i = '0;
  logic br_taken_i = 1'b0;
  logic [PW-1:0] br_target_i = '0;
  logic fetch_valid_o;
  logic [TW-1:0] fetch_tid_o;
  logic [PW-1:0] fetch_pc_o;
  logic [NS-1:0] stg_vld_o;
  logic [NS*TW-1:0] stg_tid_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mtf_sched #(
    .N_THR(NT), .PC_W(PW), .N_EX(NEX), .N_MEM(NMEM),
    .BOOT_PC(BOOT), .BOOT_STRIDE(STRIDE)
  ) u0 (.*);

  typedef struct {
    logic          vld;
    int            tid;
    logic [PW-1:0] pc;
    logic [NS-1:0] sv;
    logic [NS*TW-1:0] st;
    string         tag;
  } exp_t;

  exp_t sb_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [PW-1:0] m_pc [NT];
  logic          m_pend [NT];
  logic          m_res_hit [NT];
  int            m_rr;
  logic          m_sv [NS];
  int            m_st [NS];
  logic          m_sb [NS];
  logic          prev_bub_br;
  logic [15:0]   lf = 16'hACE1;

  function automatic logic lf_step();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  task automatic step(input int mode);
    exp_t e;
    logic v, isbr, any_pend, bv, bk;
    int t, bt;
    logic [PW-1:0] tgt;
    @(negedge clk_i);
    v = 0; t = 0;
    for (int i = NT - 1; i >= 0; i--) begin
      int k;
      k = (m_rr + i) % NT;
      if (!m_pend[k]) begin v = 1; t = k; end
    end
    any_pend = 0;
    for (int i = 0; i < NT; i++) if (m_pend[i]) any_pend = 1;
    if (mode == 0)      isbr = 0;
    else if (mode == 2) isbr = 1;
    else                isbr = lf_step() & lf_step();
    m_sv[0] = v; m_st[0] = t; m_sb[0] = v && isbr;
    e.vld = v; e.tid = t; e.pc = m_pc[t];
    for (int k = 0; k < NS; k++) begin
      e.sv[k] = m_sv[k];
      e.st[k*TW +: TW] = TW'(m_st[k]);
    end
    if (!v)                e.tag = "R6";
    else if (prev_bub_br)  e.tag = "R8";
    else if (m_res_hit[t]) e.tag = "R5";
    else if (any_pend)     e.tag = "R4";
    else if (mode == 0)    e.tag = "R3";
    else                   e.tag = "R2";
    sb_q.push_back(e);
    bv = m_sv[2] && m_sb[2];
    bt = m_st[2];
    bk = lf_step();
    tgt = {16'h0, lf[15:2], 2'b00} ^ 32'h0002_0000;
    fetch_is_br_i = isbr;
    br_valid_i = bv;
    br_tid_i = TW'(bt);
    br_taken_i = bk;
    br_target_i = tgt;
    if (bv) begin
      m_pc[bt] = bk ? tgt : m_pc[bt] + 4;
      m_pend[bt] = 0;
      m_res_hit[bt] = 1;
    end
    if (v) begin
      if (isbr) m_pend[t] = 1;
      else      m_pc[t] = m_pc[t] + 4;
      m_res_hit[t] = 0;
      m_rr = (t + 1) % NT;
    end
    prev_bub_br = !v && isbr;
    for (int k = NS - 1; k > 0; k--) begin
      m_sv[k] = m_sv[k-1]; m_st[k] = m_st[k-1]; m_sb[k] = m_sb[k-1];
    end
  endtask

  // monitor: compares the queued expectation away from the clock edge
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        logic bad;
        e = sb_q.pop_front();
        n_chk++;
        bad = (fetch_valid_o !== e.vld) ||
              (e.vld && (int'(fetch_tid_o) != e.tid || fetch_pc_o !== e.pc));
        if (bad) begin
          n_bad++;
          $display("FAIL %s fetch: got v=%0b t=%0d pc=%h exp v=%0b t=%0d pc=%h",
                   e.tag, fetch_valid_o, fetch_tid_o, fetch_pc_o, e.vld, e.tid, e.pc);
        end
        n_chk++;
        bad = (stg_vld_o !== e.sv);
        for (int k = 0; k < NS; k++)
          if (e.sv[k] && stg_tid_o[k*TW +: TW] !== e.st[k*TW +: TW]) bad = 1;
        if (bad) begin
          n_bad++;
          $display("FAIL R7 slots: got v=%b t=%b exp v=%b t=%b",
                   stg_vld_o, stg_tid_o, e.sv, e.st);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < NT; i++) begin
      m_pc[i] = BOOT + PW'(i) * STRIDE;
      m_pend[i] = 0;
      m_res_hit[i] = 0;
    end
    for (int k = 0; k < NS; k++) begin m_sv[k] = 0; m_st[k] = 0; m_sb[k] = 0; end
    m_rr = 0;
    prev_bub_br = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #1;
    n_chk++;
    if (fetch_valid_o !== 1'b1 || fetch_tid_o !== '0 || fetch_pc_o !== BOOT ||
        stg_vld_o !== NS'(1)) begin
      n_bad++;
      $display("FAIL R1 reset: got v=%0b t=%0d pc=%h slots=%b exp v=1 t=0 pc=%h slots=%b",
               fetch_valid_o, fetch_tid_o, fetch_pc_o, stg_vld_o, BOOT, NS'(1));
    end
    for (int c = 0; c < 20; c++)  step(0);  // R3, R2: no branches
    for (int c = 0; c < 80; c++)  step(1);  // R4, R5: mixed branches
    for (int c = 0; c < 40; c++)  step(2);  // R6, R8: every fetch branches
    for (int c = 0; c < 20; c++)  step(0);  // drain back to straight-line flow
    @(negedge clk_i);
    fetch_is_br_i = 0;
    br_valid_i = 0;
    @(negedge clk_i);
    #2;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule